// File: doc/BRIEF.md
# Base Timer with Selectable Reset

A 16-bit base timer that runs on a selected count enable and forms the common time reference of a timer and waveform peripheral. The count enable is one of three things: the system clock on every cycle, one of two external clock-enable strobes, or the output of a prescaler. The prescaler divides the system clock by 2(n+1). The timer counts up, counts down, or follows a direction pin. It can also decode a two-phase (quadrature) pulse pair into steps up and down.

The counter can be cleared by three sources, each with its own enable. The first is equality with the channel-0 compare value, which sets the period of the waveform channels. The second is equality with a dedicated reset value. The third is a low level on an external pin. A direct write loads the counter at any time. An overflow request pulse comes from a 1-to-0 fall of counter bit 15 or bit 14.

Top module: `base_timer`

## Requirements
- R1: While rst_ni is low, and on the first cycle after it rises, cnt_o is 0 and ovf_o is 0.
- R2: src_sel_i picks the count enable: 0 = every clock cycle, 1 = src_a_en_i, 2 = src_b_en_i, 3 = prescaler output. The enable that is not selected has no effect.
- R3: The prescaler gives one enable every 2*(div_i+1) clock cycles while start_i is 1. Its phase is cleared whenever start_i is 0, so after a restart the first enable comes a full 2*(div_i+1) cycles later.
- R4: While start_i is 0 the counter holds its value. Writes and reset sources still act.
- R5: mode_i selects the counting: 0 = up, 1 = direction from dir_i (0 up, 1 down), 3 = down. The counter wraps modulo 2^16. It moves by one on each rising edge at which the selected enable is 1.
- R6: In mode_i = 2 the counter ignores the count enable and steps once per change of {phase_a_i, phase_b_i}. The sequence 00→01→11→10→00 counts up and the reverse counts down. A change of both phases at once is ignored. The inputs pass two synchronising flops, so the count changes at the third rising edge after an input change.
- R7: With rst_en_i[0] = 1, the counter clears at the rising edge at which it equals cmp0_i. With a per-cycle enable this gives a period of cmp0_i+1.
- R8: With rst_en_i[1] = 1, the counter clears at the rising edge at which it equals rst_val_i.
- R9: With rst_en_i[2] = 1, a low ext_rst_ni is synchronised by two flops and then holds the counter at 0. The first clear lands on the third rising edge after the pin falls. Counting resumes on the third rising edge after the pin rises.
- R10: wr_en_i loads wr_data_i at the next rising edge. It takes priority over every reset source and over counting.
- R11: ovf_o is a one-cycle pulse, aligned with the new counter value, when the selected bit falls from 1 to 0 through counting. ovf_sel_i = 0 selects bit 15 and ovf_sel_i = 1 selects bit 14.
- R12: A clear or a write never raises ovf_o. Several enabled reset sources that hit together clear the counter once, and counting continues from 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Run enable; 0 freezes the counter and clears the prescaler |
| src_sel_i | input | 2 | Count-enable select |
| src_a_en_i | input | 1 | External count-enable strobe A |
| src_b_en_i | input | 1 | External count-enable strobe B |
| div_i | input | 8 | Prescaler setting n, divide by 2(n+1) |
| mode_i | input | 2 | Count mode |
| dir_i | input | 1 | Direction in mode 1, 1 = down |
| phase_a_i | input | 1 | Quadrature phase A |
| phase_b_i | input | 1 | Quadrature phase B |
| rst_en_i | input | 3 | Reset source enables: [0] compare-0, [1] reset value, [2] pin |
| cmp0_i | input | 16 | Channel-0 compare value |
| rst_val_i | input | 16 | Dedicated reset value |
| ext_rst_ni | input | 1 | External reset pin, active low |
| ovf_sel_i | input | 1 | Overflow tap: 0 = bit 15, 1 = bit 14 |
| wr_en_i | input | 1 | Counter write strobe |
| wr_data_i | input | 16 | Counter write value |
| cnt_o | output | 16 | Counter value |
| ovf_o | output | 1 | Overflow request pulse |

## Verification
A wrong prescaler phase appears at cnt_o as a step that comes early or late within one divide period. Stale synchroniser or quadrature history appears as a missing, extra or reversed step three edges after a phase change. A bad reset-hit term appears as a counter that does not wrap at the compare value, or that wraps where it should not, on the very next edge. A misplaced overflow tap shows on ovf_o in the cycle the counter crosses the boundary. A cycle-accurate reference model compares cnt_o and ovf_o on every clock, so each of these faults is caught within the cycle in which it first becomes visible.

// File: rtl/bt_pkg.sv
package bt_pkg;
  typedef enum logic [1:0] {
    SRC_SYS = 2'd0,
    SRC_A   = 2'd1,
    SRC_B   = 2'd2,
    SRC_DIV = 2'd3
  } src_e;

  typedef enum logic [1:0] {
    MODE_UP   = 2'd0,
    MODE_DIR  = 2'd1,
    MODE_QUAD = 2'd2,
    MODE_DOWN = 2'd3
  } mode_e;

  localparam int unsigned RSRC_CMP0 = 0;
  localparam int unsigned RSRC_RVAL = 1;
  localparam int unsigned RSRC_PIN  = 2;
  localparam int unsigned RSRC_N    = 3;
endpackage

// File: rtl/bt_sync.sv
module bt_sync #(
  parameter int unsigned  W       = 1,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] s1_q, s2_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s1_q <= RST_VAL;
      s2_q <= RST_VAL;
    end else begin
      s1_q <= d_i;
      s2_q <= s1_q;
    end
  end

  assign q_o = s2_q;
endmodule

// File: rtl/bt_prescaler.sv
module bt_prescaler #(
  parameter int unsigned DIV_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic [DIV_W-1:0] div_i,
  output logic             tick_o
);
  localparam int unsigned PW = DIV_W + 1;
  localparam logic [PW-1:0] P_ONE = PW'(1);

  logic [PW-1:0] pre_q;
  logic [PW-1:0] lim;

  // last phase of a 2(n+1) cycle
  assign lim    = {div_i, 1'b1};
  assign tick_o = start_i && (pre_q == lim);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       pre_q <= '0;
    else if (!start_i) pre_q <= '0;
    else if (tick_o)   pre_q <= '0;
    else               pre_q <= pre_q + P_ONE;
  end

  // R3
  property p_stop_clears;
    @(posedge clk_i) disable iff (!rst_ni) !start_i |=> !tick_o;
  endproperty
  stop_clears_chk: assert property (p_stop_clears);
endmodule

// File: rtl/bt_quad_dec.sv
module bt_quad_dec (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic phase_a_i,
  input  logic phase_b_i,
  output logic step_o,
  output logic up_o
);
  logic [1:0] cur, prev_q, diff;

  bt_sync #(.W(2), .RST_VAL(2'b00)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   ({phase_a_i, phase_b_i}),
    .q_o   (cur)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) prev_q <= 2'b00;
    else         prev_q <= cur;
  end

  assign diff   = cur ^ prev_q;
  assign step_o = ^diff;              // one phase moved, not both
  assign up_o   = prev_q[1] ^ cur[0]; // old A vs new B

  // R6
  property p_no_double;
    @(posedge clk_i) disable iff (!rst_ni)
      (cur[1] != prev_q[1]) && (cur[0] != prev_q[0]) |-> !step_o;
  endproperty
  no_double_chk: assert property (p_no_double);
endmodule

// File: rtl/bt_counter.sv
module bt_counter
  import bt_pkg::*;
#(
  parameter int unsigned W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  mode_e             mode_i,
  input  logic              dir_i,
  input  logic              tick_i,
  input  logic              qstep_i,
  input  logic              qup_i,
  input  logic [RSRC_N-1:0] rst_en_i,
  input  logic [W-1:0]      cmp0_i,
  input  logic [W-1:0]      rst_val_i,
  input  logic              pin_low_i,
  input  logic              ovf_sel_i,
  input  logic              wr_en_i,
  input  logic [W-1:0]      wr_data_i,
  output logic [W-1:0]      cnt_o,
  output logic              ovf_o
);
  localparam logic [W-1:0] ONE = W'(1);

  logic [W-1:0]      cnt_q, cnt_d;
  logic [RSRC_N-1:0] src_hit;
  logic              hit, step, up, tap_q, tap_d, ovf_d;

  always_comb begin
    src_hit            = '0;
    src_hit[RSRC_CMP0] = (cnt_q == cmp0_i);
    src_hit[RSRC_RVAL] = (cnt_q == rst_val_i);
    src_hit[RSRC_PIN]  = pin_low_i;
  end

  assign hit = |(src_hit & rst_en_i);

  always_comb begin
    step = tick_i;
    up   = 1'b1;
    unique case (mode_i)
      MODE_UP:   begin step = tick_i;  up = 1'b1;   end
      MODE_DIR:  begin step = tick_i;  up = !dir_i; end
      MODE_QUAD: begin step = qstep_i; up = qup_i;  end
      MODE_DOWN: begin step = tick_i;  up = 1'b0;   end
    endcase
    step = step && start_i;
  end

  always_comb begin
    if (wr_en_i)   cnt_d = wr_data_i;
    else if (hit)  cnt_d = '0;
    else if (step) cnt_d = up ? cnt_q + ONE : cnt_q - ONE;
    else           cnt_d = cnt_q;
  end

  assign tap_q = ovf_sel_i ? cnt_q[W-2] : cnt_q[W-1];
  assign tap_d = ovf_sel_i ? cnt_d[W-2] : cnt_d[W-1];
  assign ovf_d = !wr_en_i && !hit && tap_q && !tap_d;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      ovf_o <= 1'b0;
    end else begin
      cnt_q <= cnt_d;
      ovf_o <= ovf_d;
    end
  end

  assign cnt_o = cnt_q;

  // R10
  property p_wr_load;
    @(posedge clk_i) disable iff (!rst_ni) wr_en_i |=> cnt_q == $past(wr_data_i);
  endproperty
  wr_load_chk: assert property (p_wr_load);

  // R7 R8 R9
  property p_clear;
    @(posedge clk_i) disable iff (!rst_ni) !wr_en_i && hit |=> cnt_q == '0;
  endproperty
  clear_chk: assert property (p_clear);

  // R4
  property p_hold;
    @(posedge clk_i) disable iff (!rst_ni) !start_i && !wr_en_i && !hit |=> $stable(cnt_q);
  endproperty
  hold_chk: assert property (p_hold);

  // R5
  property p_unit_step;
    @(posedge clk_i) disable iff (!rst_ni) !wr_en_i && !hit |=>
      (cnt_q == $past(cnt_q)) || (cnt_q == $past(cnt_q) + ONE) || (cnt_q == $past(cnt_q) - ONE);
  endproperty
  unit_step_chk: assert property (p_unit_step);

  // R11
  property p_ovf_pulse;
    @(posedge clk_i) disable iff (!rst_ni) ovf_o |=> !ovf_o;
  endproperty
  ovf_pulse_chk: assert property (p_ovf_pulse);

  // R11
  property p_ovf_tap;
    @(posedge clk_i) disable iff (!rst_ni) ovf_o |->
      ($past(ovf_sel_i) ? ($past(cnt_q[W-2]) && !cnt_q[W-2])
                        : ($past(cnt_q[W-1]) && !cnt_q[W-1]));
  endproperty
  ovf_tap_chk: assert property (p_ovf_tap);

  // R12
  property p_no_ovf_on_clear;
    @(posedge clk_i) disable iff (!rst_ni) wr_en_i || hit |=> !ovf_o;
  endproperty
  no_ovf_on_clear_chk: assert property (p_no_ovf_on_clear);
endmodule

// File: rtl/base_timer.sv
module base_timer
  import bt_pkg::*;
#(
  parameter int unsigned W     = 16,
  parameter int unsigned DIV_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [1:0]        src_sel_i,
  input  logic              src_a_en_i,
  input  logic              src_b_en_i,
  input  logic [DIV_W-1:0]  div_i,
  input  logic [1:0]        mode_i,
  input  logic              dir_i,
  input  logic              phase_a_i,
  input  logic              phase_b_i,
  input  logic [2:0]        rst_en_i,
  input  logic [W-1:0]      cmp0_i,
  input  logic [W-1:0]      rst_val_i,
  input  logic              ext_rst_ni,
  input  logic              ovf_sel_i,
  input  logic              wr_en_i,
  input  logic [W-1:0]      wr_data_i,
  output logic [W-1:0]      cnt_o,
  output logic              ovf_o
);
  logic div_tick, tick, qstep, qup, pin_s;

  bt_prescaler #(.DIV_W(DIV_W)) u_pre (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .start_i(start_i),
    .div_i  (div_i),
    .tick_o (div_tick)
  );

  always_comb begin
    unique case (src_e'(src_sel_i))
      SRC_SYS: tick = 1'b1;
      SRC_A:   tick = src_a_en_i;
      SRC_B:   tick = src_b_en_i;
      SRC_DIV: tick = div_tick;
    endcase
  end

  bt_quad_dec u_quad (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .phase_a_i(phase_a_i),
    .phase_b_i(phase_b_i),
    .step_o   (qstep),
    .up_o     (qup)
  );

  bt_sync #(.W(1), .RST_VAL(1'b1)) u_pin_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (ext_rst_ni),
    .q_o   (pin_s)
  );

  bt_counter #(.W(W)) u_cnt (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .start_i  (start_i),
    .mode_i   (mode_e'(mode_i)),
    .dir_i    (dir_i),
    .tick_i   (tick),
    .qstep_i  (qstep),
    .qup_i    (qup),
    .rst_en_i (rst_en_i),
    .cmp0_i   (cmp0_i),
    .rst_val_i(rst_val_i),
    .pin_low_i(!pin_s),
    .ovf_sel_i(ovf_sel_i),
    .wr_en_i  (wr_en_i),
    .wr_data_i(wr_data_i),
    .cnt_o    (cnt_o),
    .ovf_o    (ovf_o)
  );

  // R1
  property p_reset_idle;
    @(posedge clk_i) disable iff (!rst_ni) $rose(rst_ni) |-> (cnt_o == '0) && !ovf_o;
  endproperty
  reset_idle_chk: assert property (p_reset_idle);
endmodule

// File: tb/tb_base_timer.sv
`timescale 1ns/1ps
module tb_base_timer;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [1:0]  src_sel = 2'd0;
  logic        src_a = 1'b0, src_b = 1'b0;
  logic [7:0]  div = 8'd0;
  logic [1:0]  mode = 2'd0;
  logic        dir = 1'b0;
  logic        pa = 1'b0, pb = 1'b0;
  logic [2:0]  ren = 3'd0;
  logic [15:0] cmp0 = 16'hFFFF, rv = 16'hFFFF;
  logic        ext_n = 1'b1;
  logic        ovf_sel = 1'b0;
  logic        wr = 1'b0;
  logic [15:0] wd = 16'd0;
  logic [15:0] cnt;
  logic        ovf;

  int    n_chk = 0, n_err = 0;
  bit    done = 1'b0;
  string cur_req = "R1";

  always #2.5 clk = ~clk;

  base_timer dut (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .src_sel_i(src_sel),
    .src_a_en_i(src_a), .src_b_en_i(src_b), .div_i(div), .mode_i(mode),
    .dir_i(dir), .phase_a_i(pa), .phase_b_i(pb), .rst_en_i(ren),
    .cmp0_i(cmp0), .rst_val_i(rv), .ext_rst_ni(ext_n), .ovf_sel_i(ovf_sel),
    .wr_en_i(wr), .wr_data_i(wd), .cnt_o(cnt), .ovf_o(ovf)
  );

  // behavioural reference
  logic [15:0] m_cnt;
  logic        m_ovf;
  int          m_pre;
  logic [1:0]  q1, q2, qp;
  logic        e1, e2;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_cnt = 16'd0; m_ovf = 1'b0; m_pre = 0;
      q1 = 2'b00; q2 = 2'b00; qp = 2'b00; e1 = 1'b1; e2 = 1'b1;
    end else begin
      int   lim, tb;
      bit   ptick, tk, qstep, qup, hit, stp, upd;
      logic [1:0]  qd;
      logic [15:0] nxt;
      lim   = 2 * int'(div) + 1;
      ptick = start && (m_pre == lim);
      case (src_sel)
        2'd0:    tk = 1'b1;
        2'd1:    tk = src_a;
        2'd2:    tk = src_b;
        default: tk = ptick;
      endcase
      qd    = q2 ^ qp;
      qstep = (qd == 2'b01) || (qd == 2'b10);
      qup   = qp[1] ^ q2[0];
      hit   = (ren[0] && m_cnt == cmp0) || (ren[1] && m_cnt == rv) || (ren[2] && !e2);
      case (mode)
        2'd0:    begin stp = tk;    upd = 1'b1; end
        2'd1:    begin stp = tk;    upd = !dir; end
        2'd2:    begin stp = qstep; upd = qup;  end
        default: begin stp = tk;    upd = 1'b0; end
      endcase
      if (wr)                nxt = wd;
      else if (hit)          nxt = 16'd0;
      else if (start && stp) nxt = upd ? m_cnt + 16'd1 : m_cnt - 16'd1;
      else                   nxt = m_cnt;
      tb    = ovf_sel ? 14 : 15;
      m_ovf = !wr && !hit && m_cnt[tb] && !nxt[tb];
      m_cnt = nxt;
      if (!start || ptick) m_pre = 0; else m_pre = m_pre + 1;
      qp = q2; q2 = q1; q1 = {pa, pb};
      e2 = e1; e1 = ext_n;
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n && !done) begin
      chk(cnt == m_cnt, cur_req, int'(cnt), int'(m_cnt));
      chk(ovf == m_ovf, cur_req, int'(ovf), int'(m_ovf));
    end
  end

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr_cnt(input logic [15:0] v);
    wr = 1'b1; wd = v;
    @(negedge clk);
    wr = 1'b0;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_err++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    // R1 reset state
    cyc(3);
    chk(cnt == 16'd0 && !ovf, "R1", int'(cnt), 0);
    rst_n = 1'b1;
    cyc(1);
    chk(cnt == 16'd0 && !ovf, "R1", int'(cnt), 0);

    // R2 R5 up on every cycle
    cur_req = "R2"; start = 1'b1; src_sel = 2'd0; mode = 2'd0;
    cyc(10);
    chk(cnt == 16'd10, "R2", int'(cnt), 10);

    // R4 frozen while stopped
    cur_req = "R4"; start = 1'b0;
    cyc(5);
    chk(cnt == 16'd10, "R4", int'(cnt), 10);
    wr_cnt(16'd0);
    chk(cnt == 16'd0, "R4", int'(cnt), 0);

    // R3 prescaler, divide by 6
    cur_req = "R3"; div = 8'd2; src_sel = 2'd3; start = 1'b1;
    cyc(12);
    chk(cnt == 16'd2, "R3", int'(cnt), 2);
    cyc(5);
    chk(cnt == 16'd2, "R3", int'(cnt), 2);
    start = 1'b0; cyc(1); start = 1'b1;
    cyc(5);
    chk(cnt == 16'd2, "R3", int'(cnt), 2);
    cyc(1);
    chk(cnt == 16'd3, "R3", int'(cnt), 3);

    // R2 external strobes, other strobe ignored
    cur_req = "R2"; src_sel = 2'd1; wr_cnt(16'd0);
    for (int i = 0; i < 4; i++) begin
      src_a = 1'b1; src_b = 1'b1; cyc(1);
      src_a = 1'b0; cyc(1);
    end
    src_b = 1'b0;
    chk(cnt == 16'd4, "R2", int'(cnt), 4);
    src_sel = 2'd2; src_a = 1'b1; src_b = 1'b1;
    cyc(3);
    src_a = 1'b0; src_b = 1'b0;
    chk(cnt == 16'd7, "R2", int'(cnt), 7);

    // R5 modes
    cur_req = "R5"; src_sel = 2'd0; mode = 2'd3; wr_cnt(16'd2);
    cyc(4);
    chk(cnt == 16'hFFFE, "R5", int'(cnt), 'hFFFE);
    mode = 2'd1; dir = 1'b0;
    cyc(3);
    chk(cnt == 16'h0001, "R5", int'(cnt), 1);
    dir = 1'b1;
    cyc(2);
    chk(cnt == 16'hFFFF, "R5", int'(cnt), 'hFFFF);

    // R6 quadrature
    cur_req = "R6"; mode = 2'd2; dir = 1'b0; wr_cnt(16'd0);
    {pa, pb} = 2'b01; cyc(3);
    {pa, pb} = 2'b11; cyc(3);
    {pa, pb} = 2'b10; cyc(3);
    {pa, pb} = 2'b00; cyc(4);
    chk(cnt == 16'd4, "R6", int'(cnt), 4);
    {pa, pb} = 2'b10; cyc(3);
    {pa, pb} = 2'b11; cyc(4);
    chk(cnt == 16'd2, "R6", int'(cnt), 2);
    {pa, pb} = 2'b00; cyc(4);
    chk(cnt == 16'd2, "R6", int'(cnt), 2);

    // R7 compare-0 clear
    cur_req = "R7"; mode = 2'd0; ren = 3'b001; cmp0 = 16'd5; wr_cnt(16'd0);
    cyc(5);
    chk(cnt == 16'd5, "R7", int'(cnt), 5);
    cyc(1);
    chk(cnt == 16'd0, "R7", int'(cnt), 0);

    // R8 reset-value clear
    cur_req = "R8"; ren = 3'b010; rv = 16'd3; wr_cnt(16'd0);
    cyc(3);
    chk(cnt == 16'd3, "R8", int'(cnt), 3);
    cyc(1);
    chk(cnt == 16'd0, "R8", int'(cnt), 0);

    // R9 external pin
    cur_req = "R9"; ren = 3'b100; wr_cnt(16'd0);
    ext_n = 1'b0;
    cyc(2);
    chk(cnt == 16'd2, "R9", int'(cnt), 2);
    cyc(1);
    chk(cnt == 16'd0, "R9", int'(cnt), 0);
    cyc(3);
    chk(cnt == 16'd0, "R9", int'(cnt), 0);
    ext_n = 1'b1;
    cyc(3);
    chk(cnt == 16'd1, "R9", int'(cnt), 1);

    // R10 write beats a pending compare clear
    cur_req = "R10"; ren = 3'b001; cmp0 = 16'd7; wr_cnt(16'd6);
    cyc(1);
    wr_cnt(16'h1234);
    chk(cnt == 16'h1234, "R10", int'(cnt), 'h1234);
    ren = 3'b000;

    // R11 overflow taps
    cur_req = "R11"; ovf_sel = 1'b1; wr_cnt(16'h7FFE);
    cyc(1);
    chk(!ovf, "R11", int'(ovf), 0);
    cyc(1);
    chk(ovf && cnt == 16'h8000, "R11", int'(ovf), 1);
    cyc(1);
    chk(!ovf, "R11", int'(ovf), 0);
    ovf_sel = 1'b0; wr_cnt(16'hFFFF);
    cyc(1);
    chk(ovf && cnt == 16'h0000, "R11", int'(ovf), 1);
    mode = 2'd3; wr_cnt(16'h8000);
    cyc(1);
    chk(ovf && cnt == 16'h7FFF, "R11", int'(ovf), 1);

    // R12 simultaneous sources, no overflow on clear or write
    cur_req = "R12"; mode = 2'd0; ren = 3'b011; cmp0 = 16'hFFFF; rv = 16'hFFFF;
    wr_cnt(16'hFFFE);
    cyc(1);
    chk(cnt == 16'hFFFF, "R12", int'(cnt), 'hFFFF);
    cyc(1);
    chk(cnt == 16'd0 && !ovf, "R12", int'(ovf), 0);
    cyc(1);
    chk(cnt == 16'd1, "R12", int'(cnt), 1);
    ren = 3'b000; wr_cnt(16'h8000);
    wr_cnt(16'h0001);
    chk(!ovf && cnt == 16'h0001, "R12", int'(ovf), 0);
    cyc(2);

    finish_run();
  end
endmodule